// File: doc/BRIEF.md
# Programmable 8/16-bit timer-counter

This block is a timer/counter peripheral sitting behind a simple byte-wide register bus. It advances on a single-cycle increment strobe, `inc_tick`, produced by a separate front end. That front end handles clock division or external edge qualification, so this block sees only "one increment opportunity now". Software picks 8-bit or 16-bit width, starts and stops the counter, and preloads or samples it. Each overflow raises a sticky flag. The flag drives an interrupt request when the interrupt enable is set.

The upper count byte is never on the bus directly. It moves through a buffer register:
- Reading the low byte copies the live upper byte into the buffer in the same access, so a following buffer read returns a consistent 16-bit snapshot.
- Writing the low byte loads the upper byte from the buffer in the same edge, so a 16-bit preload lands in one step.

Any low-byte write also swallows the next two increment strobes, and software compensates for this in the preload value.

Register map, with `addr` on 2 bits:

| addr | Register | Contents |
|------|----------|----------|
| 0 | control | bit 7 run, bit 6 narrow (8-bit) mode, bit 5 interrupt enable; other bits read 0 |
| 1 | count low | the live low byte |
| 2 | high buffer | the buffer for the upper byte |
| 3 | flag | bit 0 is the overflow flag; other bits read 0 |

Top module: `tmr_core`

## Requirements
- R1: After reset the count is 0x0000, the flag is 0, the control register reads 0x00 (stopped, 16-bit, interrupt disabled), the buffer reads 0x00 and `irq` is 0.
- R2: With control bit 7 clear, `inc_tick` strobes leave the count unchanged. Control bits 7, 6 and 5 read back as written.
- R3: In 16-bit mode (control bit 6 clear) each accepted strobe adds one to the 16-bit count. A strobe taken at 0xFFFF gives 0x0000 and sets the flag.
- R4: In 8-bit mode (control bit 6 set) only the low byte counts and the upper byte keeps its value. A strobe taken at low byte 0xFF wraps it to 0x00 and sets the flag.
- R5: A read of address 1 returns the live low byte and, in that same access, loads the buffer with the live upper byte. Address 2 reads return the buffer.
- R6: A write to address 1 loads the low byte from the write data and, on the same edge, loads the upper byte from the buffer.
- R7: A write to address 2 changes only the buffer and leaves the live count unchanged.
- R8: After a write to address 1, the next two `inc_tick` strobes are ignored and the third is counted.
- R9: The flag stays set until a write to address 3 with bit 0 equal to 0. A write to address 3 with bit 0 equal to 1 has no effect.
- R10: If a flag-clearing write and an overflow occur in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when the flag is set and control bit 5 is set.
- R12: In 16-bit mode, a preload of 0x85EE overflows on exactly the 31250th counted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_tick | input | 1 | Single-cycle increment opportunity from the front end |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on address 1) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle:
- the count holds while stopped or during holdoff;
- the upper byte holds in 8-bit mode;
- a low-byte write lands buffer and data together;
- a low-byte read snapshots the upper byte;
- the flag is sticky and set at a 16-bit wrap.

Other behaviour only the bench's register-level scenarios can show. This covers the two-strobe holdoff as seen through a later readback, the clear-versus-overflow race, the exact 31250-strobe period from the 0x85EE preload, and the interrupt gating as seen on `irq`.

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DW   = 8,
  parameter int AW   = 2,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int RUN_B = DW - 1;
  localparam int NAR_B = DW - 2;
  localparam int IE_B  = DW - 3;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_LO   = AW'(1);
  localparam logic [AW-1:0] A_BUF  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);

  logic          run_q, nar_q, ie_q, flag_q;
  logic [DW-1:0] lo_q, hi_q, buf_q;
  logic [HW-1:0] hold_q;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_lo   = wr_en && addr == A_LO;
  wire wr_buf  = wr_en && addr == A_BUF;
  wire wr_flag = wr_en && addr == A_FLAG;
  wire rd_lo   = rd_en && addr == A_LO;

  wire step = run_q && inc_tick && hold_q == '0 && !wr_lo;
  wire lo_max = &lo_q;
  wire hi_max = &hi_q;
  wire ovf = step && lo_max && (nar_q || hi_max);

  assign irq = flag_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      nar_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= wdata[RUN_B];
      nar_q <= wdata[NAR_B];
      ie_q  <= wdata[IE_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wdata;
      hi_q <= buf_q;
    end else if (step) begin
      lo_q <= lo_q + 1'b1;
      if (!nar_q && lo_max) hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (wr_buf) buf_q <= wdata;
    else if (rd_lo)  buf_q <= hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hold_q <= '0;
    else if (wr_lo)                     hold_q <= HW'(HOLD);
    else if (inc_tick && hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag_q <= 1'b0;
    else if (ovf)                   flag_q <= 1'b1;
    else if (wr_flag && !wdata[0])  flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[RUN_B] = run_q;
        rdata[NAR_B] = nar_q;
        rdata[IE_B]  = ie_q;
      end
      A_LO:    rdata = lo_q;
      A_BUF:   rdata = buf_q;
      default: rdata[0] = flag_q;
    endcase
  end

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_lo) |=> ($stable(lo_q) && $stable(hi_q)));

  p_wrap16_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !nar_q && inc_tick && hold_q == '0 && !wr_lo && lo_max && hi_max)
    |=> (flag_q && lo_q == '0 && hi_q == '0));

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_q && !wr_lo) |=> $stable(hi_q));

  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_buf) |=> (buf_q == $past(hi_q)));

  p_atomic_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata) && hi_q == $past(buf_q)));

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0 && !wr_lo) |=> ($stable(lo_q) && $stable(hi_q)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_flag && !wdata[0])) |=> flag_q);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && ie_q));
endmodule

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  tmr_core u0 (
    .clk(clk), .rst_n(rst_n), .inc_tick(inc_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual %02h", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %0d actual %02h expected %02h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [15:0] e, input string t);
    rd(2'd1, e[7:0], t);
    rd(2'd2, e[15:8], t);
  endtask

  task automatic tick(input int n);
    inc_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    inc_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(2'd0, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");
    rd(2'd3, 8'h00, "R1");
    rd16(16'h0000, "R1");

    // R2 stopped counter ignores strobes
    tick(5);
    rd16(16'h0000, "R2");

    // R3 running 16-bit count
    wr(2'd0, 8'h80);
    rd(2'd0, 8'h80, "R2");
    tick(3);
    rd16(16'h0003, "R3");

    // R7 buffer write alone, R5 low read refreshes buffer
    wr(2'd2, 8'hAB);
    rd(2'd2, 8'hAB, "R7");
    rd(2'd1, 8'h03, "R7");
    rd(2'd2, 8'h00, "R5");

    // R6 atomic load, R8 holdoff of two strobes
    wr(2'd2, 8'h12);
    wr(2'd1, 8'h34);
    rd16(16'h1234, "R6");
    tick(2);
    rd16(16'h1234, "R8");
    tick(1);
    rd16(16'h1235, "R8");

    // R3 16-bit wrap
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFE);
    tick(3);
    rd(2'd3, 8'h00, "R3");
    rd16(16'hFFFF, "R3");
    tick(1);
    rd(2'd3, 8'h01, "R3");
    rd16(16'h0000, "R3");

    // R11 interrupt gating
    chk_irq(1'b0, "R11");
    wr(2'd0, 8'hA0);
    chk_irq(1'b1, "R11");
    wr(2'd0, 8'h80);
    chk_irq(1'b0, "R11");

    // R9 sticky flag
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h01, "R9");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R9");

    // R4 8-bit mode
    wr(2'd0, 8'hC0);
    rd(2'd0, 8'hC0, "R2");
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'hFE);
    tick(3);
    rd(2'd3, 8'h00, "R4");
    rd16(16'h5AFF, "R4");
    tick(1);
    rd(2'd3, 8'h01, "R4");
    rd16(16'h5A00, "R4");

    // R10 clear racing an overflow
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R10");
    wr(2'd1, 8'hFF);
    tick(2);
    wr_en = 1'b1; addr = 2'd3; wdata = 8'h00; inc_tick = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; inc_tick = 1'b0;
    rd(2'd3, 8'h01, "R10");
    rd(2'd1, 8'h00, "R10");

    // R12 preload period
    wr(2'd0, 8'h80);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h85);
    wr(2'd1, 8'hEE);
    tick(2);
    tick(31249);
    rd(2'd3, 8'h00, "R12");
    rd16(16'hFFFF, "R12");
    tick(1);
    rd(2'd3, 8'h01, "R12");
    rd16(16'h0000, "R12");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule